// File: doc/BRIEF.md
# Frame and Multiframe Timer Events

This block produces the periodic timing events of a T1/E1 framer, separately for the transmit and the receive direction. A bit-clock enable for each direction advances that direction's bit and frame counters. From these counters the block derives three events: a frame boundary, a multiframe boundary and a signaling multiframe boundary. Two more events come from single-cycle multiframe sync inputs on the system-bus side. All eight events are caught in one sticky status byte, which a read strobe clears as a whole. A per-bit enable mask decides which latched events drive the interrupt line.

The frame length comes from the line mode: 193 bits for T1 and 256 bits for E1. The multiframe length comes from the framing format. The block also keeps a transmit phase bit that flips on every transmit frame boundary. Software reads it to pick the half of the transmit slip buffer it may touch. When the line mode or the framing format changes, both directions restart at bit 0 of frame 0.

Top module: `frame_timer_events`

## Requirements
- R1: A frame event fires on every bit-enable cycle whose bit position is 0. A frame is 193 bit enables long when `line_e1`=0 and 256 when `line_e1`=1. After a restart, the first bit enable is bit 0 of frame 0.
- R2: A multiframe event fires on bit 0 of frame 0. The number of frames per multiframe depends on `fmt`: 0 (SF/SLC) gives 12, 1 (ESF) gives 24, 2 (E1 basic) gives 16 and 3 (E1 CAS) gives 16.
- R3: A signaling multiframe event fires together with each multiframe event, except when `fmt`=2, where it never fires.
- R4: Status bit positions, from bit 7 down to bit 0, are: tx signaling multiframe, tx bus sync, tx multiframe, tx frame, rx signaling multiframe, rx bus sync, rx multiframe, rx frame.
- R5: An event sets its status bit in the cycle after the bit enable that produced it. The bit stays set until a cycle with `rd_clr` high, which clears the whole byte. Reset leaves the byte at 0.
- R6: An event that comes in the same cycle as `rd_clr` is still latched.
- R7: A bus sync bit is set on a rising edge of `tx_bus_sync` or `rx_bus_sync`. An input held high sets its bit only once.
- R8: `irq` is high exactly when some status bit and its `irq_en` bit are both set. Status bits latch even when their enable is 0.
- R9: `tx_half` is 0 after reset and toggles with every transmit frame event.
- R10: Any change of `fmt` or `line_e1` sends both directions back to bit 0 of frame 0.
- R11: The transmit events depend only on `tx_bit_en`, and the receive events depend only on `rx_bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_bit_en | input | 1 | Transmit bit-clock enable |
| rx_bit_en | input | 1 | Receive bit-clock enable |
| line_e1 | input | 1 | Line mode: 0 T1, 1 E1 |
| fmt | input | 2 | Framing format: 0 SF/SLC, 1 ESF, 2 E1 basic, 3 E1 CAS |
| tx_bus_sync | input | 1 | Transmit system-bus multiframe sync pulse |
| rx_bus_sync | input | 1 | Receive system-bus multiframe sync pulse |
| irq_en | input | 8 | Interrupt enable per status bit |
| rd_clr | input | 1 | Status read strobe, clears the whole byte |
| status | output | 8 | Sticky timer event status |
| irq | output | 1 | Interrupt request |
| tx_half | output | 1 | Transmit slip-buffer half phase |

## Verification
The hardest cases to reach from the ports are the multiframe boundaries far into a run and the windows that end exactly one bit before or on a boundary. Because the status bits are sticky, a plain run only shows that some event happened at some point. To get around this, the stimulus first restarts the counters by toggling the format. It then spends a chosen number of bit enables, clears the status, and opens a counted window of bit enables. A boundary's status bit is set only if that boundary falls inside the window. Windows that stop one bit short of a boundary, and windows that end on it, pin down each period exactly.

// File: rtl/ftev_pkg.sv
// Shared definitions for the frame timer events block.
// Assumes a two-bit framing format code and a fixed status bit order.
package ftev_pkg;
    typedef enum logic [1:0] {
        FMT_SF    = 2'd0,
        FMT_ESF   = 2'd1,
        FMT_E1B   = 2'd2,
        FMT_E1CAS = 2'd3
    } fmt_e;

    localparam int ST_TX_SIG = 7;
    localparam int ST_TX_BUS = 6;
    localparam int ST_TX_MF  = 5;
    localparam int ST_TX_FR  = 4;
    localparam int ST_RX_SIG = 3;
    localparam int ST_RX_BUS = 2;
    localparam int ST_RX_MF  = 1;
    localparam int ST_RX_FR  = 0;
endpackage

// File: rtl/ftev_dir_counter.sv
// Bit and frame position counter for one direction.
// Emits single-cycle frame, multiframe and signaling events on bit 0.
// Assumes frame_len >= 2 and mf_len >= 1; restart has priority over bit_en.
module ftev_dir_counter #(
    parameter int BW = 8,
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          restart,
    input  logic [BW-1:0] frame_len,
    input  logic [FW-1:0] mf_len,
    input  logic          sig_ok,
    output logic          frame_evt,
    output logic          mf_evt,
    output logic          sig_evt
);
    logic [BW-1:0] bit_pos;
    logic [FW-1:0] frm_pos;

    // Boundary decode of the current position on an enabled bit.
    always_comb begin
        frame_evt = bit_en && !restart && (bit_pos == '0);
        mf_evt    = frame_evt && (frm_pos == '0);
        sig_evt   = mf_evt && sig_ok;
    end

    // Position advance with wrap at frame and multiframe ends.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            bit_pos <= '0;
            frm_pos <= '0;
        end else if (bit_en) begin
            if (bit_pos == frame_len - BW'(1)) begin
                bit_pos <= '0;
                if (frm_pos == mf_len - FW'(1)) frm_pos <= '0;
                else                            frm_pos <= frm_pos + FW'(1);
            end else begin
                bit_pos <= bit_pos + BW'(1);
            end
        end
    end
endmodule

// File: rtl/ftev_status_reg.sv
// Sticky status byte with whole-register clear on read.
// Assumes set pulses are single-cycle; a set beats a coincident clear.
module ftev_status_reg #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_vec,
    input  logic          rd_clr,
    output logic [NB-1:0] status
);
    // Latch new events, drop old ones on read.
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= '0;
        else if (rd_clr) status <= set_vec;
        else             status <= status | set_vec;
    end
endmodule

// File: rtl/frame_timer_events.sv
// Frame and multiframe timer events for both directions of a T1/E1 framer.
// Derives periods from line mode and format, restarts counters on any
// configuration change, latches events and gates the interrupt.
// Assumes bus sync inputs are synchronous to clk.
module frame_timer_events #(
    parameter int T1_BITS    = 193,
    parameter int E1_BITS    = 256,
    parameter int SF_FRAMES  = 12,
    parameter int ESF_FRAMES = 24,
    parameter int E1_FRAMES  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_bit_en,
    input  logic       rx_bit_en,
    input  logic       line_e1,
    input  logic [1:0] fmt,
    input  logic       tx_bus_sync,
    input  logic       rx_bus_sync,
    input  logic [7:0] irq_en,
    input  logic       rd_clr,
    output logic [7:0] status,
    output logic       irq,
    output logic       tx_half
);
    import ftev_pkg::*;

    localparam int MAXB = (E1_BITS > T1_BITS) ? E1_BITS : T1_BITS;
    localparam int MAXF0 = (ESF_FRAMES > SF_FRAMES) ? ESF_FRAMES : SF_FRAMES;
    localparam int MAXF = (E1_FRAMES > MAXF0) ? E1_FRAMES : MAXF0;
    localparam int BW = $clog2(MAXB);
    localparam int FW = $clog2(MAXF) + 1;
    localparam int ND = 2;   // index 0 receive, 1 transmit

    logic [2:0]    cfg_q;
    logic          restart;
    logic [BW-1:0] frame_len;
    logic [FW-1:0] mf_len;
    logic          sig_ok;
    logic [ND-1:0] bit_en;
    logic [ND-1:0] fr_e, mf_e, sg_e;
    logic [ND-1:0] bus_in, bus_q;
    logic [7:0]    set_vec;

    // Remember the configuration to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= 3'b000;
        else        cfg_q <= {line_e1, fmt};
    end

    // Period selection from line mode and framing format.
    always_comb begin
        restart   = ({line_e1, fmt} != cfg_q);
        frame_len = line_e1 ? BW'(E1_BITS) : BW'(T1_BITS);
        unique case (fmt_e'(fmt))
            FMT_SF:  mf_len = FW'(SF_FRAMES);
            FMT_ESF: mf_len = FW'(ESF_FRAMES);
            default: mf_len = FW'(E1_FRAMES);
        endcase
        sig_ok = (fmt_e'(fmt) != FMT_E1B);
        bit_en = {tx_bit_en, rx_bit_en};
        bus_in = {tx_bus_sync, rx_bus_sync};
    end

    generate
        for (genvar d = 0; d < ND; d++) begin : g_dir
            ftev_dir_counter #(.BW(BW), .FW(FW)) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .bit_en    (bit_en[d]),
                .restart   (restart),
                .frame_len (frame_len),
                .mf_len    (mf_len),
                .sig_ok    (sig_ok),
                .frame_evt (fr_e[d]),
                .mf_evt    (mf_e[d]),
                .sig_evt   (sg_e[d])
            );
        end
    endgenerate

    // Previous level of the bus sync inputs for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_in;
    end

    // Assemble the event vector in status bit order.
    always_comb begin
        set_vec            = '0;
        set_vec[ST_TX_SIG] = sg_e[1];
        set_vec[ST_TX_BUS] = bus_in[1] & ~bus_q[1];
        set_vec[ST_TX_MF]  = mf_e[1];
        set_vec[ST_TX_FR]  = fr_e[1];
        set_vec[ST_RX_SIG] = sg_e[0];
        set_vec[ST_RX_BUS] = bus_in[0] & ~bus_q[0];
        set_vec[ST_RX_MF]  = mf_e[0];
        set_vec[ST_RX_FR]  = fr_e[0];
    end

    ftev_status_reg #(.NB(8)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd_clr  (rd_clr),
        .status  (status)
    );

    // Slip-buffer half flips at every transmit frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_half <= 1'b0;
        else if (fr_e[1]) tx_half <= ~tx_half;
    end

    // Interrupt from enabled status bits.
    always_comb irq = |(status & irq_en);
endmodule

// File: rtl/ftev_checker.sv
// Temporal checks for frame_timer_events, attached by bind.
// Assumes the port names of the top module.
module ftev_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_bit_en,
    input logic       rx_bit_en,
    input logic [1:0] fmt,
    input logic       tx_bus_sync,
    input logic       rx_bus_sync,
    input logic [7:0] irq_en,
    input logic       rd_clr,
    input logic [7:0] status,
    input logic       irq,
    input logic       tx_half
);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && status[4]) |=> status[4]);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !tx_bit_en && !rx_bit_en && !tx_bus_sync && !rx_bus_sync)
        |=> (status == 8'h00));

    p_mf_on_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> status[4]);

    p_no_sig_e1b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 2'd2) |=> !$rose(status[3]));

    p_tx_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit_en |=> !$rose(status[4]));

    p_rx_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_en |=> !$rose(status[0]));

    p_half_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_half) |-> status[4]);

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 8'h00) |-> !irq);
endmodule

bind frame_timer_events ftev_checker u_chk (.*);

// File: tb/frame_timer_events_bench.sv
module frame_timer_events_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_bit_en = 1'b0, rx_bit_en = 1'b0;
    logic       line_e1 = 1'b0;
    logic [1:0] fmt = 2'd0;
    logic       tx_bus_sync = 1'b0, rx_bus_sync = 1'b0;
    logic [7:0] irq_en = 8'h00;
    logic       rd_clr = 1'b0;
    logic [7:0] status;
    logic       irq, tx_half;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    frame_timer_events u_frame_timer_events (
        .clk(clk), .rst_n(rst_n), .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en),
        .line_e1(line_e1), .fmt(fmt), .tx_bus_sync(tx_bus_sync),
        .rx_bus_sync(rx_bus_sync), .irq_en(irq_en), .rd_clr(rd_clr),
        .status(status), .irq(irq), .tx_half(tx_half)
    );

    // Window vectors: line, format, bits skipped, window bits, expected status.
    localparam int NV = 10;
    localparam logic       V_LINE [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
    localparam logic [1:0] V_FMT  [NV] = '{0, 0, 0, 0, 1, 1, 2, 3, 3, 3};
    localparam int         V_SKIP [NV] = '{1, 1, 1, 1, 1, 2316, 1, 1, 1, 1};
    localparam int         V_WIN  [NV] = '{192, 193, 2316, 2315, 4632, 2316, 4096, 4096, 255, 256};
    localparam logic [7:0] V_EXP  [NV] = '{8'h00, 8'h11, 8'hBB, 8'h11, 8'hBB,
                                          8'h11, 8'h33, 8'hBB, 8'h00, 8'h11};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic run_bits(input int n, input logic tx, input logic rx);
        tx_bit_en = tx;
        rx_bit_en = rx;
        repeat (n) tick();
        tx_bit_en = 1'b0;
        rx_bit_en = 1'b0;
    endtask

    task automatic clear();
        rd_clr = 1'b1;
        tick();
        rd_clr = 1'b0;
    endtask

    task automatic restart(input logic ln, input logic [1:0] f);
        fmt = f ^ 2'd1;
        line_e1 = ln;
        tick();
        fmt = f;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic h0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R5 R9: reset state
        chk("R5 reset status", status, 8'h00);
        chk("R9 reset tx_half", {7'd0, tx_half}, 8'h00);
        chk("R8 reset irq", {7'd0, irq}, 8'h00);

        // R1 R2 R3 R4: window vectors
        for (int i = 0; i < NV; i++) begin
            restart(V_LINE[i], V_FMT[i]);
            run_bits(V_SKIP[i], 1'b1, 1'b1);
            clear();
            run_bits(V_WIN[i], 1'b1, 1'b1);
            chk($sformatf("R1 R2 R3 R4 vector %0d", i), status, V_EXP[i]);
        end

        // R10: format change mid-frame restarts at frame 0 bit 0
        restart(1'b0, 2'd0);
        run_bits(100, 1'b1, 1'b1);
        fmt = 2'd1;
        tick();
        clear();
        run_bits(1, 1'b1, 1'b1);
        chk("R10 restart on format change", status, 8'hBB);

        // R10: line mode change also restarts
        run_bits(50, 1'b1, 1'b1);
        line_e1 = 1'b1;
        tick();
        clear();
        run_bits(1, 1'b1, 1'b1);
        chk("R10 restart on line change", status, 8'hBB);

        // R5: sticky hold without read
        tick();
        tick();
        chk("R5 sticky hold", status, 8'hBB);

        // R8: masked bits still latch, irq follows enables
        irq_en = 8'h00; #1;
        chk("R8 masked latch", status, 8'hBB);
        chk("R8 irq masked", {7'd0, irq}, 8'h00);
        irq_en = 8'h40; #1;
        chk("R8 irq on unset bit", {7'd0, irq}, 8'h00);
        irq_en = 8'h02; #1;
        chk("R8 irq on rx mf", {7'd0, irq}, 8'h01);
        irq_en = 8'h00;

        // R6: event coincident with read survives
        restart(1'b0, 2'd1);
        rd_clr = 1'b1;
        tx_bit_en = 1'b1;
        rx_bit_en = 1'b1;
        tick();
        rd_clr = 1'b0;
        tx_bit_en = 1'b0;
        rx_bit_en = 1'b0;
        chk("R6 event kept on read", status, 8'hBB);

        // R11: transmit only
        restart(1'b0, 2'd0);
        clear();
        run_bits(1, 1'b1, 1'b0);
        chk("R11 tx only", status, 8'hB0);
        clear();
        run_bits(193, 1'b0, 1'b1);
        chk("R11 rx only", status, 8'hBB & 8'h0F);

        // R9: tx_half toggles per transmit frame
        restart(1'b0, 2'd0);
        h0 = tx_half;
        run_bits(1, 1'b1, 1'b0);
        chk("R9 toggle at frame start", {7'd0, tx_half}, {7'd0, ~h0});
        run_bits(192, 1'b1, 1'b0);
        chk("R9 stable inside frame", {7'd0, tx_half}, {7'd0, ~h0});
        run_bits(1, 1'b1, 1'b0);
        chk("R9 toggle at next frame", {7'd0, tx_half}, {7'd0, h0});

        // R7: bus sync rising edges
        clear();
        tx_bus_sync = 1'b1;
        tick();
        chk("R7 tx bus sync", status, 8'h40);
        clear();
        repeat (3) tick();
        chk("R7 held high sets once", status, 8'h00);
        tx_bus_sync = 1'b0;
        tick();
        tx_bus_sync = 1'b1;
        tick();
        tx_bus_sync = 1'b0;
        chk("R7 tx new edge", status, 8'h40);
        clear();
        rx_bus_sync = 1'b1;
        tick();
        rx_bus_sync = 1'b0;
        chk("R7 rx bus sync", status, 8'h04);

        // R5: read clears whole byte
        clear();
        chk("R5 clear", status, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule